// File: doc/BRIEF.md
# Remote Configuration Request Engine

This block lets a local host reach the configuration space of a remote bus segment that has no root complex of its own. Software sees three word registers on a small write/read bus: a control word, a data word and a status word. The control word selects a configuration read or write and names the remote target and register. A write to the data word launches the operation. For a write operation, the written value is also the payload. The engine then presents one request on a valid/ready port toward the remote side and waits for the matching completion on a completion port.

Each launch stamps the request with a fresh tag. A completion is taken only if its tag matches the request that is outstanding. When a completion is taken, the engine clears busy, sets done and records how the completion ended. After a successful read, the returned word is placed in the data register. Software can give up on an operation whose completion was lost by writing one to the done flag. Busy then drops at once, and any completion that arrives later is discarded. Only the local side can start operations: the remote side has no path back into this block.

Top module: `rcfg_engine`

## Requirements
- R1: After reset the status word reads 0 (busy 0, done 0, code 0) and `req_valid` is 0.
- R2: Register addresses are 0 = control, 1 = data and 2 = status. The control word holds the operation in bit 31 (1 = write, 0 = read), the register number in bits [16 +: REG_W] and the target in bits [0 +: TGT_W], and it reads back as it was written. The status word holds busy in bit 0, done in bit 1 and the completion code in bits [5:4]. All other bits read 0.
- R3: A data write while busy is 0 loads the data register and sets busy and clears done and code, all in the same cycle. From the next cycle it also drives `req_valid` with the control fields, the payload and a tag equal to the previous tag plus one modulo 2^TAG_W (the tag is 0 after reset). The request is held stable until `req_ready` is seen.
- R4: A data write while busy is 1 is ignored: no new request or tag, and the data register is unchanged.
- R5: A control write while busy is 1 is ignored: the control readback and the request fields are unchanged.
- R6: A completion whose tag matches, arriving after the request was accepted, clears busy, sets done and copies `cpl_code` (0 success, 1 unsupported request, 2 completer abort) into the code field.
- R7: A successful read completion writes `cpl_data` into the data register. A failed read, or any write completion, leaves the data register unchanged.
- R8: Writing 1 to status bit 1 while busy aborts the operation. Busy goes to 0, done to 1 and the code to 3, and a request that was not yet accepted is withdrawn (`req_valid` goes to 0).
- R9: A completion is discarded when the engine is not busy (for example after an abort) or when its tag is not the current one (a stale completion after a relaunch). It changes neither the status word nor the data register.
- R10: Writing 1 to status bit 1 while not busy clears done and leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and readback |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the addressed register |
| req_valid | output | 1 | Request to the remote side is present |
| req_ready | input | 1 | Remote side accepts the request |
| req_write | output | 1 | 1 = configuration write, 0 = read |
| req_target | output | TGT_W | Remote target identifier |
| req_reg | output | REG_W | Remote register number |
| req_data | output | 32 | Write payload |
| req_tag | output | TAG_W | Tag of this launch |
| cpl_valid | input | 1 | Completion is present |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| cpl_code | input | 2 | Completion outcome (0 ok, 1 unsupported, 2 completer abort) |
| cpl_data | input | 32 | Read data returned by the completion |

## Verification
The bench builds the engine with TGT_W = 16 and REG_W = 12, which match the control word field positions. It uses TAG_W = 2 so that the tag wraps after four launches, and a short run of back-to-back reads therefore crosses the wrap. The narrow tag also lets the bench inject a stale completion from the previous launch right after a relaunch, and confirm that only the new tag is taken. A behavioural remote responder can accept normally, never accept, or accept and stay silent. These modes drive the abort of an unaccepted request and the abort of a lost completion.

// File: rtl/rcfg_pkg.sv
`timescale 1ns/1ps
package rcfg_pkg;
    localparam int BUS_W    = 32;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam int OP_BIT   = 31;
    localparam int REG_LSB  = 16;
    localparam int BUSY_BIT = 0;
    localparam int DONE_BIT = 1;
    localparam int CODE_LSB = 4;

    typedef enum logic [1:0] {
        CPL_OK      = 2'd0,
        CPL_UR      = 2'd1,
        CPL_CA      = 2'd2,
        CPL_SWABORT = 2'd3
    } code_e;
endpackage

// File: rtl/rcfg_tag_gen.sv
`timescale 1ns/1ps
module rcfg_tag_gen #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    output logic [TAG_W-1:0] cur_tag
);
    typedef struct packed {
        logic [TAG_W-1:0] tag;
    } tag_s;

    tag_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (launch) begin
            t_d.tag = t_q.tag + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign cur_tag = t_q.tag;
endmodule

// File: rtl/rcfg_req_issue.sv
`timescale 1ns/1ps
module rcfg_req_issue (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic kill,
    input  logic cpl_take,
    input  logic req_ready,
    output logic req_valid,
    output logic sent
);
    typedef struct packed {
        logic pend;
        logic sent;
    } iss_s;

    iss_s i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (launch) begin
            i_d.pend = 1'b1;
            i_d.sent = 1'b0;
        end else if (kill) begin
            i_d.pend = 1'b0;
            i_d.sent = 1'b0;
        end else if (i_q.pend && req_ready) begin
            i_d.pend = 1'b0;
            i_d.sent = 1'b1;
        end else if (cpl_take) begin
            i_d.sent = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign req_valid = i_q.pend;
    assign sent      = i_q.sent;
endmodule

// File: rtl/rcfg_cpl_filter.sv
`timescale 1ns/1ps
module rcfg_cpl_filter #(
    parameter int TAG_W = 4
) (
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic             busy,
    input  logic             sent,
    input  logic [TAG_W-1:0] cur_tag,
    output logic             cpl_take
);
    logic tag_hit;

    always_comb begin
        tag_hit  = (cpl_tag == cur_tag);
        cpl_take = cpl_valid && busy && sent && tag_hit;
    end
endmodule

// File: rtl/rcfg_regmux.sv
`timescale 1ns/1ps
module rcfg_regmux
    import rcfg_pkg::*;
#(
    parameter int TGT_W = 16,
    parameter int REG_W = 12
) (
    input  logic [1:0]       addr,
    input  logic             op,
    input  logic [TGT_W-1:0] tgt,
    input  logic [REG_W-1:0] regn,
    input  logic [BUS_W-1:0] data,
    input  logic             busy,
    input  logic             done,
    input  logic [1:0]       code,
    output logic [BUS_W-1:0] rdata
);
    logic [BUS_W-1:0] ctrl_w;
    logic [BUS_W-1:0] stat_w;

    always_comb begin
        ctrl_w                   = '0;
        ctrl_w[OP_BIT]           = op;
        ctrl_w[REG_LSB +: REG_W] = regn;
        ctrl_w[0 +: TGT_W]       = tgt;

        stat_w                 = '0;
        stat_w[BUSY_BIT]       = busy;
        stat_w[DONE_BIT]       = done;
        stat_w[CODE_LSB +: 2]  = code;

        case (addr)
            A_CTRL:  rdata = ctrl_w;
            A_DATA:  rdata = data;
            A_STAT:  rdata = stat_w;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/rcfg_engine.sv
`timescale 1ns/1ps
module rcfg_engine
    import rcfg_pkg::*;
#(
    parameter int TGT_W = 16,
    parameter int REG_W = 12,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             req_write,
    output logic [TGT_W-1:0] req_target,
    output logic [REG_W-1:0] req_reg,
    output logic [31:0]      req_data,
    output logic [TAG_W-1:0] req_tag,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [1:0]       cpl_code,
    input  logic [31:0]      cpl_data
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [1:0]       code;
        logic             op;
        logic [TGT_W-1:0] tgt;
        logic [REG_W-1:0] regn;
        logic [31:0]      data;
    } eng_s;

    eng_s s_d, s_q;

    logic             wr_ctrl, wr_data, wr_stat;
    logic             launch, abort, done_clr;
    logic             cpl_take, sent;
    logic [TAG_W-1:0] cur_tag;
    logic             busy_w, done_w;
    logic [1:0]       code_w;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata;

    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
        wr_data  = reg_wr && (reg_addr == A_DATA);
        wr_stat  = reg_wr && (reg_addr == A_STAT);
        launch   = wr_data && !s_q.busy;
        abort    = wr_stat && reg_wdata[DONE_BIT] && s_q.busy;
        done_clr = wr_stat && reg_wdata[DONE_BIT] && !s_q.busy;
    end

    always_comb begin
        s_d = s_q;
        if (wr_ctrl && !s_q.busy) begin
            s_d.op   = reg_wdata[OP_BIT];
            s_d.regn = reg_wdata[REG_LSB +: REG_W];
            s_d.tgt  = reg_wdata[0 +: TGT_W];
        end
        if (launch) begin
            s_d.data = reg_wdata;
            s_d.busy = 1'b1;
            s_d.done = 1'b0;
            s_d.code = CPL_OK;
        end else if (abort) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.code = CPL_SWABORT;
        end else if (cpl_take) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.code = cpl_code;
            if (!s_q.op && (cpl_code == CPL_OK)) begin
                s_d.data = cpl_data;
            end
        end
        if (done_clr) begin
            s_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    rcfg_tag_gen #(.TAG_W(TAG_W)) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .cur_tag (cur_tag)
    );

    rcfg_req_issue u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .kill      (abort),
        .cpl_take  (cpl_take),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .sent      (sent)
    );

    rcfg_cpl_filter #(.TAG_W(TAG_W)) u_filt (
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .busy      (s_q.busy),
        .sent      (sent),
        .cur_tag   (cur_tag),
        .cpl_take  (cpl_take)
    );

    assign busy_w = s_q.busy;
    assign done_w = s_q.done;
    assign code_w = s_q.code;

    rcfg_regmux #(.TGT_W(TGT_W), .REG_W(REG_W)) u_mux (
        .addr  (reg_addr),
        .op    (s_q.op),
        .tgt   (s_q.tgt),
        .regn  (s_q.regn),
        .data  (s_q.data),
        .busy  (busy_w),
        .done  (done_w),
        .code  (code_w),
        .rdata (reg_rdata)
    );

    assign req_write  = s_q.op;
    assign req_target = s_q.tgt;
    assign req_reg    = s_q.regn;
    assign req_data   = s_q.data;
    assign req_tag    = cur_tag;
endmodule

// File: rtl/rcfg_engine_chk.sv
`timescale 1ns/1ps
module rcfg_engine_chk #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             wbit_done,
    input logic             req_valid,
    input logic             req_ready,
    input logic [TAG_W-1:0] req_tag,
    input logic             busy,
    input logic             done,
    input logic [1:0]       code
);
    logic stat_one;
    logic data_wr;

    assign stat_one = reg_wr && (reg_addr == 2'd2) && wbit_done;
    assign data_wr  = reg_wr && (reg_addr == 2'd1);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !stat_one) |=> (req_valid && $stable(req_tag))); // R3

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !busy) |=> (busy && !done && code == 2'd0)); // R3

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> $stable(req_tag)); // R4

    AST_ABORT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_one && busy) |=> (!busy && done && code == 2'd3 && !req_valid)); // R8

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy); // R8

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_one && !busy) |=> (!done && $stable(code))); // R10

    always_comb begin
        if (rst_n) begin
            AST_DONE_EXCL_BUSY: assert (!(done && busy)); // R6
        end
    end
endmodule

bind rcfg_engine rcfg_engine_chk #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wbit_done (reg_wdata[1]),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_tag   (req_tag),
    .busy      (busy_w),
    .done      (done_w),
    .code      (code_w)
);

// File: tb/sim_rcfg_engine.sv
`timescale 1ns/1ps
module sim_rcfg_engine;
    localparam int TGT_W = 16;
    localparam int REG_W = 12;
    localparam int TAG_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             req_valid, req_write;
    logic             req_ready;
    logic [TGT_W-1:0] req_target;
    logic [REG_W-1:0] req_reg;
    logic [31:0]      req_data;
    logic [TAG_W-1:0] req_tag;
    logic             cpl_valid;
    logic [TAG_W-1:0] cpl_tag;
    logic [1:0]       cpl_code;
    logic [31:0]      cpl_data;

    int n_chk = 0;
    int n_bad = 0;

    // responder controls: 0 normal, 1 never ready, 2 accept and stay silent
    int               mode = 0;
    int               lat = 3;
    logic             inj_go = 1'b0;
    logic [TAG_W-1:0] inj_tag = '0;
    logic [1:0]       inj_code = 2'd0;
    logic [31:0]      inj_data = '0;
    logic [TAG_W-1:0] last_tag = '0;
    logic [TAG_W-1:0] etag = '0;
    logic [31:0]      mem [16];

    always #2.5 clk = ~clk;

    rcfg_engine #(.TGT_W(TGT_W), .REG_W(REG_W), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_target(req_target),
        .req_reg(req_reg), .req_data(req_data), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_code(cpl_code),
        .cpl_data(cpl_data)
    );

    // behavioural remote responder: target 1 exists, register numbers >= 0x100 abort
    initial begin : responder
        logic             h_wr;
        logic [TGT_W-1:0] h_tgt;
        logic [REG_W-1:0] h_reg;
        logic [31:0]      h_dat;
        logic [TAG_W-1:0] h_tag;
        logic             pend;
        int               cnt;
        pend = 1'b0;
        cnt = 0;
        h_wr = 1'b0; h_tgt = '0; h_reg = '0; h_dat = '0; h_tag = '0;
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        req_ready = 1'b0;
        cpl_valid = 1'b0; cpl_tag = '0; cpl_code = 2'd0; cpl_data = '0;
        forever begin
            @(negedge clk);
            req_ready = 1'b0;
            cpl_valid = 1'b0;
            if (inj_go) begin
                cpl_valid = 1'b1; cpl_tag = inj_tag; cpl_code = inj_code; cpl_data = inj_data;
                inj_go = 1'b0;
            end else if (pend) begin
                if (cnt == 0) begin
                    pend = 1'b0;
                    cpl_valid = 1'b1;
                    cpl_tag = h_tag;
                    cpl_data = 32'h0;
                    if (h_tgt != 16'h0001) cpl_code = 2'd1;
                    else if (h_reg >= 12'h100) cpl_code = 2'd2;
                    else begin
                        cpl_code = 2'd0;
                        if (!h_wr) cpl_data = mem[h_reg[3:0]];
                    end
                end else begin
                    cnt--;
                end
            end else if (req_valid && mode != 1) begin
                req_ready = 1'b1;
                h_wr = req_write; h_tgt = req_target; h_reg = req_reg;
                h_dat = req_data; h_tag = req_tag;
                last_tag = req_tag;
                if (h_wr && h_tgt == 16'h0001 && h_reg < 12'h100) mem[h_reg[3:0]] = h_dat;
                if (mode == 0) begin
                    pend = 1'b1;
                    cnt = lat;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic launch(input logic [31:0] d);
        reg_write(2'd1, d);
        etag = etag + 1'b1;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 60; i++) begin
            reg_read(2'd2, s);
            if (s[1]) break;
            @(negedge clk);
        end
    endtask

    task automatic inject(input logic [TAG_W-1:0] t, input logic [1:0] c, input logic [31:0] d);
        @(negedge clk);
        #0.5;
        inj_tag = t; inj_code = c; inj_data = d; inj_go = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(2'd2, v);
        check("R1 status after reset", v, 32'h0);
        check("R1 req_valid after reset", {31'b0, req_valid}, 32'h0);
        reg_write(2'd0, 32'h8005_0001);
        reg_read(2'd0, v);
        check("R2 control readback", v, 32'h8005_0001);
        reg_read(2'd3, v);
        check("R2 unused address", v, 32'h0);
    endtask

    task automatic t_write_ok();
        logic [31:0] v;
        mode = 0; lat = 3;
        reg_write(2'd0, 32'h8003_0001);
        launch(32'hCAFE_0003);
        check("R3 req_valid after launch", {31'b0, req_valid}, 32'h1);
        check("R3 req_write", {31'b0, req_write}, 32'h1);
        check("R3 req_target", {16'b0, req_target}, 32'h1);
        check("R3 req_reg", {20'b0, req_reg}, 32'h3);
        check("R3 req_data", req_data, 32'hCAFE_0003);
        check("R3 req_tag", {30'b0, req_tag}, {30'b0, etag});
        reg_read(2'd2, v);
        check("R3 busy after launch", v, 32'h1);
        wait_done();
        reg_read(2'd2, v);
        check("R6 write success status", v, 32'h2);
        reg_read(2'd1, v);
        check("R7 data kept on write completion", v, 32'hCAFE_0003);
    endtask

    task automatic t_reads();
        logic [31:0] v;
        reg_write(2'd0, 32'h0003_0001);
        launch(32'h0000_1111);
        wait_done();
        reg_read(2'd2, v);
        check("R6 read success status", v, 32'h2);
        reg_read(2'd1, v);
        check("R7 read data returned", v, 32'hCAFE_0003);
        reg_write(2'd0, 32'h0003_0007);
        launch(32'h0000_0055);
        wait_done();
        reg_read(2'd2, v);
        check("R6 unsupported code", v, 32'h12);
        reg_read(2'd1, v);
        check("R7 data kept on failed read", v, 32'h55);
        reg_write(2'd0, 32'h0100_0001);
        launch(32'h0000_0066);
        wait_done();
        reg_read(2'd2, v);
        check("R6 completer abort code", v, 32'h22);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        logic [TAG_W-1:0] t0;
        mode = 1;
        reg_write(2'd0, 32'h0003_0001);
        launch(32'h0000_000A);
        t0 = req_tag;
        reg_write(2'd1, 32'h0000_000B);
        reg_read(2'd1, v);
        check("R4 data unchanged while busy", v, 32'hA);
        check("R4 tag unchanged while busy", {30'b0, req_tag}, {30'b0, t0});
        reg_write(2'd0, 32'h8000_0009);
        reg_read(2'd0, v);
        check("R5 control unchanged while busy", v, 32'h0003_0001);
        check("R5 request target unchanged", {16'b0, req_target}, 32'h1);
        reg_write(2'd2, 32'h2);
        check("R8 request withdrawn", {31'b0, req_valid}, 32'h0);
        reg_read(2'd2, v);
        check("R8 abort status", v, 32'h32);
        mode = 0;
    endtask

    task automatic t_late();
        logic [31:0] v;
        logic [TAG_W-1:0] stale;
        mode = 2;
        reg_write(2'd0, 32'h0003_0001);
        launch(32'h0000_0123);
        repeat (3) @(negedge clk);
        reg_read(2'd2, v);
        check("R8 busy while completion lost", v, 32'h1);
        reg_write(2'd2, 32'h2);
        reg_read(2'd2, v);
        check("R8 abort after acceptance", v, 32'h32);
        stale = last_tag;
        inject(stale, 2'd0, 32'hDEAD_BEEF);
        reg_read(2'd2, v);
        check("R9 late completion status", v, 32'h32);
        reg_read(2'd1, v);
        check("R9 late completion data", v, 32'h123);
        launch(32'h0000_0200);
        repeat (2) @(negedge clk);
        inject(stale, 2'd0, 32'hBAD0_0000);
        reg_read(2'd2, v);
        check("R9 stale tag ignored", v, 32'h1);
        inject(last_tag, 2'd0, 32'h0000_0077);
        reg_read(2'd2, v);
        check("R6 matching tag taken", v, 32'h2);
        reg_read(2'd1, v);
        check("R7 matching tag data", v, 32'h77);
        mode = 0;
    endtask

    task automatic t_idle();
        logic [31:0] v;
        reg_write(2'd2, 32'h2);
        reg_read(2'd2, v);
        check("R10 done cleared while idle", v, 32'h0);
        inject(req_tag, 2'd1, 32'h1234_5678);
        reg_read(2'd2, v);
        check("R9 idle completion status", v, 32'h0);
        reg_read(2'd1, v);
        check("R9 idle completion data", v, 32'h77);
        reg_write(2'd0, 32'h0003_0007);
        launch(32'h0);
        wait_done();
        reg_write(2'd2, 32'h2);
        reg_read(2'd2, v);
        check("R10 code kept when done cleared", v, 32'h10);
    endtask

    task automatic t_tag_wrap();
        reg_write(2'd0, 32'h0003_0001);
        for (int k = 0; k < 5; k++) begin
            launch(32'h0);
            check("R3 tag sequence across wrap", {30'b0, req_tag}, {30'b0, etag});
            wait_done();
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_ok();
        t_reads();
        t_busy_ignore();
        t_late();
        t_idle();
        t_tag_wrap();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule